// File: doc/BRIEF.md
# Two-Phase Control Register Port

This block is a small control register file reached over one shared 10-bit bus that carries first a register address and then a data word. A control/ancillary select line must be low for control-register access. A direction line picks a write (low) or a read (high). Each phase is latched by a rising edge of a strobe input, which is sampled in the block's clock domain. The bus is modelled as a split input word, an output word and an output enable that drives an external tri-state buffer.

The file holds two registers. The test register stores a 6-bit pattern-select field and the pattern generator enable bit. Its bit 7 always reads back the live pass/fail result from the self-test logic. The routing register chooses, for each pin of a small multi-function output port, which test-register bit drives that pin.

The phase tracker is a two-state machine. In `PH_ADDR`, the transition `T_ADR_LATCH` fires on a strobe edge while the select line is low: the bus word is captured as the address and the machine moves to `PH_DATA`. In `PH_DATA`, the transition `T_DATA_DONE` fires on the next strobe edge: a write is committed if the direction is write, and the machine returns to `PH_ADDR`. The transition `T_DESELECT` returns to `PH_ADDR` from either state whenever the select line is high.

Top module: `ctl_regport`

## Requirements
- R1: After reset the test register reads 000h apart from bit 7, the routing register holds 97h, the phase is address, and the bus output enable is low.
- R2: With select low and direction low, a first strobe rising edge latches the bus word as the address. A second strobe rising edge writes the bus word into the addressed register, taking effect at that clock edge.
- R3: The test register sits at address 00Dh. Bits [5:0] are the pattern select and bit 9 is the generator enable, so writing 343h gives pattern select 03h with the enable set. Bits 8 and 6 are stored and read back.
- R4: Bit 7 of the test register is read-only. A write leaves no stored value there, and a read always returns the current level of the pass/fail input in bit 7.
- R5: The bus output enable is high only in the data phase while select is low and direction is read, and the read word then is the addressed register value.
- R6: After each data-phase strobe edge, whether read or write, the next strobe edge is taken as an address.
- R7: Select high returns the port to the address phase, and strobe edges seen while select is high are ignored.
- R8: Writes to any address other than 00Dh and 00Eh change nothing, and reads from them return 000h.
- R9: The routing register at 00Eh holds one 4-bit index per output pin (pin 0 in bits [3:0], pin 1 in bits [7:4]). Pin k shows the readable test-register bit at that index, including the pass/fail bit at index 7, and shows 0 for an index of 10 or more.
- R10: The routing register reads back its 8 stored bits in [7:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_anc | input | 1 | Low selects control-register access |
| dir_rd | input | 1 | High read, low write |
| strobe | input | 1 | Phase latch strobe, rising edge active |
| ad_i | input | 10 | Bus word from the pins |
| ad_o | output | 10 | Read word toward the pins |
| ad_oe | output | 1 | Drive enable for the bus buffer |
| selftest_pass | input | 1 | Pass/fail result from self-test logic |
| pat_sel | output | 6 | Selected test pattern code |
| tpg_en | output | 1 | Pattern generator enable |
| mfio | output | 2 | Multi-function output pins |

## Verification
The port is exercised with back-to-back write and read cycles to both mapped addresses. These show whether the address and data phases alternate correctly and whether the direction line alone selects the drive. Writes that set bit 7 and reads taken under both levels of the pass/fail input tell a stored bit apart from a live status bit. Cycles to unmapped addresses, strobes during deselect, and deselect in the middle of a cycle tell the phase-reset paths apart from the normal data completion. Routing indices that point at a stored bit, at the status bit and past the register's width tell the pin selection apart from a fixed wiring.

// File: rtl/ctl_regport_pkg.sv
package ctl_regport_pkg;
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/ctl_strobe_edge.sv
module ctl_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    output logic rise
);
    logic strb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb;
    end

    assign rise = strb & ~strb_q;
endmodule

// File: rtl/ctl_phase_fsm.sv
module ctl_phase_fsm
    import ctl_regport_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_anc,
    input  logic          dir_rd,
    input  logic          rise,
    input  logic [DW-1:0] ad_i,
    output phase_t        phase,
    output logic [DW-1:0] addr_q,
    output logic          wr_fire,
    output logic          rd_drive
);
    phase_t nxt;
    logic   adr_take;

    // next-state decode
    always_comb begin
        nxt      = phase;
        adr_take = 1'b0;
        unique case (phase)
            PH_ADDR: begin
                if (!sel_anc && rise) begin
                    nxt      = PH_DATA;   // T_ADR_LATCH
                    adr_take = 1'b1;
                end
            end
            PH_DATA: begin
                if (sel_anc)   nxt = PH_ADDR; // T_DESELECT
                else if (rise) nxt = PH_ADDR; // T_DATA_DONE
            end
            default: nxt = PH_ADDR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_ADDR;
            addr_q <= '0;
        end else begin
            phase <= nxt;
            if (adr_take) addr_q <= ad_i;
        end
    end

    // outputs
    always_comb begin
        wr_fire  = 1'b0;
        rd_drive = 1'b0;
        unique case (phase)
            PH_ADDR: ;
            PH_DATA: begin
                wr_fire  = !sel_anc && rise && !dir_rd;
                rd_drive = !sel_anc && dir_rd;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_test_regs.sv
module ctl_test_regs #(
    parameter int          DW        = 10,
    parameter int          RW        = 8,
    parameter logic [9:0]  TEST_ADR  = 10'h00D,
    parameter logic [9:0]  ROUTE_ADR = 10'h00E,
    parameter int          PF_BIT    = 7,
    parameter logic [7:0]  ROUTE_RST = 8'h97
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          pass,
    output logic [DW-1:0] test_view,
    output logic [RW-1:0] route,
    output logic [DW-1:0] rdata
);
    localparam logic [DW-1:0] PF_MASK = DW'(1) << PF_BIT;

    logic [DW-1:0] test_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q <= '0;
            route  <= RW'(ROUTE_RST);
        end else if (wr_fire) begin
            if (addr == DW'(TEST_ADR))  test_q <= wdata & ~PF_MASK;
            if (addr == DW'(ROUTE_ADR)) route  <= wdata[RW-1:0];
        end
    end

    always_comb begin
        test_view         = test_q;
        test_view[PF_BIT] = pass;
    end

    always_comb begin
        if (addr == DW'(TEST_ADR))       rdata = test_view;
        else if (addr == DW'(ROUTE_ADR)) rdata = {{(DW-RW){1'b0}}, route};
        else                             rdata = '0;
    end
endmodule

// File: rtl/ctl_pin_router.sv
module ctl_pin_router #(
    parameter int DW   = 10,
    parameter int NPIN = 2,
    parameter int SELW = 4
) (
    input  logic [DW-1:0]        test_view,
    input  logic [NPIN*SELW-1:0] route,
    output logic [NPIN-1:0]      pins
);
    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        logic [SELW-1:0] idx;
        assign idx = route[k*SELW +: SELW];
        always_comb begin
            pins[k] = 1'b0;
            for (int b = 0; b < DW; b++) begin
                if (int'(idx) == b) pins[k] = test_view[b];
            end
        end
    end
endmodule

// File: rtl/ctl_regport.sv
module ctl_regport
    import ctl_regport_pkg::*;
#(
    parameter int         DW        = 10,
    parameter int         NPIN      = 2,
    parameter int         SELW      = 4,
    parameter int         PSW       = 6,
    parameter int         EN_BIT    = 9,
    parameter int         PF_BIT    = 7,
    parameter logic [9:0] TEST_ADR  = 10'h00D,
    parameter logic [9:0] ROUTE_ADR = 10'h00E,
    parameter logic [7:0] ROUTE_RST = 8'h97
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_anc,
    input  logic            dir_rd,
    input  logic            strobe,
    input  logic [DW-1:0]   ad_i,
    output logic [DW-1:0]   ad_o,
    output logic            ad_oe,
    input  logic            selftest_pass,
    output logic [PSW-1:0]  pat_sel,
    output logic            tpg_en,
    output logic [NPIN-1:0] mfio
);
    localparam int RW = NPIN * SELW;

    logic          rise;
    phase_t        phase;
    logic [DW-1:0] addr_q;
    logic          wr_fire;
    logic          rd_drive;
    logic [DW-1:0] test_view;
    logic [RW-1:0] route;
    logic [DW-1:0] rdata;

    ctl_strobe_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .strb  (strobe),
        .rise  (rise)
    );

    ctl_phase_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_anc  (sel_anc),
        .dir_rd   (dir_rd),
        .rise     (rise),
        .ad_i     (ad_i),
        .phase    (phase),
        .addr_q   (addr_q),
        .wr_fire  (wr_fire),
        .rd_drive (rd_drive)
    );

    ctl_test_regs #(
        .DW(DW), .RW(RW), .TEST_ADR(TEST_ADR), .ROUTE_ADR(ROUTE_ADR),
        .PF_BIT(PF_BIT), .ROUTE_RST(ROUTE_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_fire),
        .addr      (addr_q),
        .wdata     (ad_i),
        .pass      (selftest_pass),
        .test_view (test_view),
        .route     (route),
        .rdata     (rdata)
    );

    ctl_pin_router #(.DW(DW), .NPIN(NPIN), .SELW(SELW)) u_route (
        .test_view (test_view),
        .route     (route),
        .pins      (mfio)
    );

    assign ad_oe   = rd_drive;
    assign ad_o    = rd_drive ? rdata : '0;
    assign pat_sel = test_view[PSW-1:0];
    assign tpg_en  = test_view[EN_BIT];
endmodule

// File: rtl/ctl_regport_chk.sv
module ctl_regport_chk
    import ctl_regport_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel_anc,
    input logic       dir_rd,
    input logic       rise,
    input logic [9:0] ad_o,
    input logic       ad_oe,
    input logic       selftest_pass,
    input logic [5:0] pat_sel,
    input logic       tpg_en,
    input phase_t     phase,
    input logic [9:0] addr_q,
    input logic       wr_fire
);
    a_r5_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!sel_anc && dir_rd && phase == PH_DATA));

    a_r7_deselect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        sel_anc |=> (phase == PH_ADDR));

    a_r6_data_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && rise && !sel_anc) |=> (phase == PH_ADDR));

    a_r4_live_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && addr_q == 10'h00D) |-> (ad_o[7] == selftest_pass));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && addr_q != 10'h00D && addr_q != 10'h00E) |-> (ad_o == 10'h000));

    a_r2_pat_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pat_sel) |-> $past(wr_fire));

    a_r3_en_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tpg_en) |-> $past(wr_fire));
endmodule

bind ctl_regport ctl_regport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_anc       (sel_anc),
    .dir_rd        (dir_rd),
    .rise          (rise),
    .ad_o          (ad_o),
    .ad_oe         (ad_oe),
    .selftest_pass (selftest_pass),
    .pat_sel       (pat_sel),
    .tpg_en        (tpg_en),
    .phase         (phase),
    .addr_q        (addr_q),
    .wr_fire       (wr_fire)
);

// File: tb/sim_ctl_regport.sv
`timescale 1ns/1ps
module sim_ctl_regport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b1;
    logic       rd = 1'b0;
    logic       stb = 1'b0;
    logic [9:0] adi = '0;
    logic       pass = 1'b0;
    logic [9:0] ado;
    logic       oe;
    logic [5:0] psel;
    logic       en;
    logic [1:0] pins;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int m_prev, m_phase, m_addr, m_test, m_route;

    ctl_regport u0 (
        .clk(clk), .rst_n(rst_n), .sel_anc(sel), .dir_rd(rd), .strobe(stb),
        .ad_i(adi), .ad_o(ado), .ad_oe(oe), .selftest_pass(pass),
        .pat_sel(psel), .tpg_en(en), .mfio(pins)
    );

    always #2.5 clk = ~clk;

    function automatic int view_test();
        int v = m_test & ~32'h80;
        if (pass) v = v | 32'h80;
        return v;
    endfunction

    function automatic int exp_read();
        if (m_addr == 'h00D) return view_test();
        if (m_addr == 'h00E) return m_route;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = 0; m_phase = 0; m_addr = 0; m_test = 0; m_route = 'h97;
    endtask

    task automatic model_edge();
        int rise = (stb && !m_prev) ? 1 : 0;
        if (sel) m_phase = 0;
        else if (rise != 0) begin
            if (m_phase == 0) begin
                m_addr = int'(adi); m_phase = 1;
            end else begin
                if (!rd) begin
                    if (m_addr == 'h00D) m_test  = int'(adi) & ~32'h80;
                    if (m_addr == 'h00E) m_route = int'(adi) & 'hFF;
                end
                m_phase = 0;
            end
        end
        m_prev = stb ? 1 : 0;
    endtask

    task automatic compare();
        int eoe = (m_phase == 1 && !sel && rd) ? 1 : 0;
        int v = view_test();
        chk(int'(oe) == eoe, "R5 oe", int'(oe), eoe);
        if (eoe != 0) chk(int'(ado) == exp_read(), "R4 R8 R10 read word", int'(ado), exp_read());
        chk(int'(psel) == (m_test & 'h3F), "R2 pat_sel", int'(psel), m_test & 'h3F);
        chk(int'(en) == ((m_test >> 9) & 1), "R3 tpg_en", int'(en), (m_test >> 9) & 1);
        for (int k = 0; k < 2; k++) begin
            int idx = (m_route >> (4 * k)) & 'hF;
            int ep = (idx < 10) ? ((v >> idx) & 1) : 0;
            chk(int'(pins[k]) == ep, "R9 mfio", int'(pins[k]), ep);
        end
    endtask

    task automatic step(input logic s, input logic r, input logic st, input logic [9:0] d);
        sel = s; rd = r; stb = st; adi = d;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic wr(input logic [9:0] a, input logic [9:0] d);
        step(0, 0, 1, a); step(0, 0, 0, a);
        step(0, 0, 1, d); step(0, 0, 0, d);
    endtask

    task automatic rdc(input logic [9:0] a);
        step(0, 1, 1, a); step(0, 1, 0, 0);
        step(0, 1, 1, 0); step(0, 1, 0, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk(oe == 1'b0, "R1 oe after reset", int'(oe), 0);
        chk(psel == 6'h00 && en == 1'b0, "R1 test reg after reset", int'({en, psel}), 0);
        chk(pins == 2'b00, "R1 routed pins after reset", int'(pins), 0);
        step(1, 0, 0, 0);
        rdc(10'h00E);                       // R10 reset route value
        // R3 pattern write
        wr(10'h00D, 10'h343);
        chk(psel == 6'h03 && en, "R3 343h write", int'({en, psel}), 'h43);
        pass = 1'b0; rdc(10'h00D);
        pass = 1'b1; rdc(10'h00D);          // R4 live status
        wr(10'h00D, 10'h0BF);               // R4 bit 7 written high
        pass = 1'b0; rdc(10'h00D);
        // R8 unmapped
        wr(10'h055, 10'h3FF);
        chk(psel == 6'h3F, "R8 prior value kept", int'(psel), 'h3F);
        rdc(10'h055);
        rdc(10'h3FF);
        // R9 routing: pin0 -> bit 0, pin1 -> index 12 (out of range)
        wr(10'h00E, 10'h0C0);
        rdc(10'h00E);
        wr(10'h00E, 10'h079);               // pin0 -> bit 9, pin1 -> pass/fail
        pass = 1'b1; step(0, 0, 0, 0);
        pass = 1'b0; step(0, 0, 0, 0);
        // R6 next strobe after a write is an address
        wr(10'h00D, 10'h201);
        step(0, 1, 1, 10'h00D); step(0, 1, 0, 0);
        chk(oe == 1'b1 && ado == 10'h201, "R6 address after data", int'(ado), 'h201);
        step(0, 1, 1, 0); step(0, 1, 0, 0);
        // R7 deselect mid-cycle, then strobes while deselected
        step(0, 0, 1, 10'h00D); step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 1, 10'h3C5); step(1, 0, 0, 0);
        step(0, 0, 1, 10'h00D); step(0, 0, 0, 0);
        step(0, 0, 1, 10'h012); step(0, 0, 0, 0);
        chk(psel == 6'h12 && !en, "R7 deselect restarts at address", int'({en, psel}), 'h12);
        step(1, 1, 1, 0);
        chk(oe == 1'b0, "R7 no drive while deselected", int'(oe), 0);
        step(1, 1, 0, 0);
        // R2 mixed direction: read then write back to back
        rdc(10'h00E);
        wr(10'h00D, 10'h3FF);
        rdc(10'h00D);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule